// File: doc/BRIEF.md
# Variable Pulse Width Symbol Receiver

This block listens to a single-wire bus that carries data as pulse widths. It times the gap between each pair of bus edges, sorts that gap into a symbol class, and turns the classes into data bits, bytes and frame events. One bit comes from each interval. Its value depends on two things: whether the interval was short or long, and whether the bus was high (active) or low (passive) during it. A high interval in the start-of-frame range opens a frame. An overlong high interval is a break that aborts the frame. A quiet period with no valid symbol closes the frame.

Time is counted in ticks, which the surrounding logic supplies as a one-cycle enable. The default thresholds assume a 0.8 us tick. Bits are shifted in most-significant first. Each completed byte appears for one cycle together with its position in the frame. The frame events (start, end, end with a partial byte, break) are also single-cycle pulses. CRC checking and frame storage belong to downstream logic.

Top module: `pulse_width_rx`

## Requirements
- R1: The bus input passes through a two-flop synchronizer. An interval is the number of enabled ticks between two edges. A high interval decodes as 1 when it lasts 42 to 119 ticks (short) and as 0 when it lasts 120 to 203 ticks (long). A low interval decodes as 0 when short and as 1 when long.
- R2: Any interval under 42 ticks is ignored as noise. A low interval of 204 ticks or more is also ignored. Neither one produces an output or changes the frame state.
- R3: A high interval of 204 to 298 ticks is a start of frame. It pulses `frameStart` and clears the bit count and the byte position. Data bits that arrive before any start of frame are dropped.
- R4: Bits shift in MSB first. On the eighth bit, `byteValid` pulses for one cycle with the byte on `byteData` and its 0-based position in the frame on `byteIndex`.
- R5: A frame delivers at most 12 bytes. Later bytes in the same frame are discarded.
- R6: While a frame is open, 350 ticks with no valid symbol pulse `frameEnd` and close the frame. Every valid short, long or start-of-frame symbol restarts this timer.
- R7: `frameError` pulses together with `frameEnd` only when the frame closes with between 1 and 7 bits of an unfinished byte.
- R8: A high interval of 299 ticks or more pulses `breakSeen`. It clears all frame state, and that frame produces no `frameEnd`. Reception resumes at the next start of frame, with byte positions starting again at 0.
- R9: After reset, no symbol is acted on until the synchronized bus has stayed low for 350 ticks.
- R10: The interval counter saturates rather than wrapping, so a high level held for any length of time is reported as a break.
- R11: Intervals are measured only on cycles where `tickEn` is high, so spreading the ticks out gives the same decode.
- R12: While reset is held and right after it, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle timing tick for interval counting |
| busIn | input | 1 | Asynchronous bus level, high is active |
| byteData | output | 8 | Received byte, valid with byteValid |
| byteValid | output | 1 | One-cycle strobe for a completed byte |
| byteIndex | output | 4 | Position of the byte within its frame, from 0 |
| frameStart | output | 1 | Pulse on a start-of-frame symbol |
| frameEnd | output | 1 | Pulse when the inactivity time closes a frame |
| frameError | output | 1 | Pulse with frameEnd when an unfinished byte was pending |
| breakSeen | output | 1 | Pulse on a break symbol |

## Verification
A wrong class threshold or a swapped level rule shows up within one byte as a wrong `byteData` value. A bit counter or byte position that is not cleared shows up at the next start of frame as an index that is not 0, or as a byte built from leftover bits. An inactivity timer that is not restarted makes `frameEnd` fire in the middle of a slow frame instead of 350 ticks after its last edge. A counter that wraps turns a long stuck-high level into a data bit instead of a `breakSeen` pulse.

// File: rtl/pwrx_pkg.sv
package pwrx_pkg;

  typedef enum logic [1:0] {
    SYM_SHORT,
    SYM_LONG,
    SYM_SOF,
    SYM_BREAK
  } symKind_t;

  typedef enum logic [1:0] {
    ST_WAIT_IDLE,
    ST_HUNT,
    ST_FRAME
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrFrame;
    logic rstInact;
    logic shiftEn;
    logic bitVal;
  } rxCtrl_t;

endpackage

// File: rtl/pwrx_measure.sv
module pwrx_measure import pwrx_pkg::*; #(
  parameter int CNT_W     = 10,
  parameter int SYNC_N    = 2,
  parameter int SHORT_MIN = 42,
  parameter int LONG_MIN  = 120,
  parameter int SOF_MIN   = 204,
  parameter int BRK_MIN   = 299,
  parameter int EOF_TICKS = 350
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tickEn,
  input  logic     busIn,
  output logic     symValid,
  output symKind_t symKind,
  output logic     symLevel,
  output logic     lowIdle
);

  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_MIN);
  localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_MIN);
  localparam logic [CNT_W-1:0] SOF_LIM   = CNT_W'(SOF_MIN);
  localparam logic [CNT_W-1:0] BRK_LIM   = CNT_W'(BRK_MIN);
  localparam logic [CNT_W-1:0] EOF_LIM   = CNT_W'(EOF_TICKS);

  logic [SYNC_N-1:0] syncQ;
  logic              busSync;
  logic              busPrev;
  logic              edgeSeen;
  logic [CNT_W-1:0]  cnt;
  logic              keepNext;
  symKind_t          kindNext;

  assign busSync  = syncQ[SYNC_N-1];
  assign edgeSeen = busSync ^ busPrev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syncQ   <= '0;
      busPrev <= 1'b0;
      cnt     <= '0;
    end else begin
      syncQ   <= {syncQ[SYNC_N-2:0], busIn};
      busPrev <= busSync;
      if (edgeSeen) begin
        cnt <= tickEn ? CNT_W'(1) : '0;
      end else if (tickEn && (cnt != CNT_MAX)) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // sort the finished interval; busPrev is its level
  always_comb begin
    keepNext = 1'b1;
    kindNext = SYM_SHORT;
    if (cnt < SHORT_LIM) begin
      keepNext = 1'b0;
    end else if (cnt < LONG_LIM) begin
      kindNext = SYM_SHORT;
    end else if (cnt < SOF_LIM) begin
      kindNext = SYM_LONG;
    end else if (!busPrev) begin
      keepNext = 1'b0;
    end else if (cnt < BRK_LIM) begin
      kindNext = SYM_SOF;
    end else begin
      kindNext = SYM_BREAK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      symValid <= 1'b0;
      symKind  <= SYM_SHORT;
      symLevel <= 1'b0;
    end else begin
      symValid <= edgeSeen && keepNext;
      symKind  <= kindNext;
      symLevel <= busPrev;
    end
  end

  assign lowIdle = !busSync && (cnt >= EOF_LIM);

  assert_sat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !edgeSeen) |=> (cnt == CNT_MAX));

  assert_min_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    symValid |-> ($past(cnt) >= SHORT_LIM));

  assert_low_data_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (symValid && !symLevel) |-> (symKind == SYM_SHORT || symKind == SYM_LONG));

endmodule

// File: rtl/pwrx_datapath.sv
module pwrx_datapath import pwrx_pkg::*; #(
  parameter int CNT_W     = 10,
  parameter int EOF_TICKS = 350,
  parameter int MAX_BYTES = 12,
  parameter int IDX_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tickEn,
  input  rxCtrl_t          ctrl,
  input  logic             inactRun,
  output logic [7:0]       byteData,
  output logic             byteValid,
  output logic [IDX_W-1:0] byteIndex,
  output logic             partialByte,
  output logic             inactDone
);

  localparam logic [CNT_W-1:0] EOF_LIM = CNT_W'(EOF_TICKS);
  localparam logic [IDX_W-1:0] MAX_LIM = IDX_W'(MAX_BYTES);

  logic [6:0]       shReg;
  logic [2:0]       bitCnt;
  logic [IDX_W-1:0] byteIdx;
  logic [CNT_W-1:0] inactCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shReg     <= '0;
      bitCnt    <= '0;
      byteIdx   <= '0;
      byteData  <= '0;
      byteValid <= 1'b0;
      byteIndex <= '0;
    end else begin
      byteValid <= 1'b0;
      if (ctrl.clrFrame) begin
        shReg   <= '0;
        bitCnt  <= '0;
        byteIdx <= '0;
      end else if (ctrl.shiftEn) begin
        shReg  <= {shReg[5:0], ctrl.bitVal};
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == 3'd7) begin
          byteData  <= {shReg, ctrl.bitVal};
          byteIndex <= byteIdx;
          byteValid <= (byteIdx < MAX_LIM);
          if (byteIdx != MAX_LIM) begin
            byteIdx <= byteIdx + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inactCnt <= '0;
    end else if (ctrl.clrFrame || ctrl.rstInact) begin
      inactCnt <= '0;
    end else if (inactRun && tickEn && (inactCnt < EOF_LIM)) begin
      inactCnt <= inactCnt + 1'b1;
    end
  end

  assign partialByte = (bitCnt != 3'd0);
  assign inactDone   = (inactCnt >= EOF_LIM);

  assert_index_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byteValid |-> (byteIndex < MAX_LIM));

  assert_byte_on_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byteValid |-> $past(ctrl.shiftEn));

  assert_inact_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl.rstInact) |-> !inactDone);

endmodule

// File: rtl/pwrx_control.sv
module pwrx_control import pwrx_pkg::*; (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     symValid,
  input  symKind_t symKind,
  input  logic     symLevel,
  input  logic     lowIdle,
  input  logic     inactDone,
  input  logic     partialByte,
  output rxCtrl_t  ctrl,
  output logic     inactRun,
  output logic     frameStart,
  output logic     frameEnd,
  output logic     frameError,
  output logic     breakSeen
);

  rxState_t state, stateNext;
  logic startNext, endNext, errNext, brkNext;

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    startNext = 1'b0;
    endNext   = 1'b0;
    errNext   = 1'b0;
    brkNext   = 1'b0;
    unique case (state)
      ST_WAIT_IDLE: begin
        if (lowIdle) stateNext = ST_HUNT;
      end
      ST_HUNT: begin
        if (symValid && symKind == SYM_SOF) begin
          ctrl.clrFrame = 1'b1;
          ctrl.rstInact = 1'b1;
          startNext     = 1'b1;
          stateNext     = ST_FRAME;
        end else if (symValid && symKind == SYM_BREAK) begin
          ctrl.clrFrame = 1'b1;
          brkNext       = 1'b1;
        end
      end
      ST_FRAME: begin
        if (symValid) begin
          unique case (symKind)
            SYM_SOF: begin
              ctrl.clrFrame = 1'b1;
              ctrl.rstInact = 1'b1;
              startNext     = 1'b1;
            end
            SYM_BREAK: begin
              ctrl.clrFrame = 1'b1;
              brkNext       = 1'b1;
              stateNext     = ST_HUNT;
            end
            default: begin
              ctrl.shiftEn  = 1'b1;
              ctrl.rstInact = 1'b1;
              ctrl.bitVal   = symLevel ? (symKind == SYM_SHORT) : (symKind == SYM_LONG);
            end
          endcase
        end else if (inactDone) begin
          endNext       = 1'b1;
          errNext       = partialByte;
          ctrl.clrFrame = 1'b1;
          stateNext     = ST_HUNT;
        end
      end
      default: stateNext = ST_WAIT_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_WAIT_IDLE;
      frameStart <= 1'b0;
      frameEnd   <= 1'b0;
      frameError <= 1'b0;
      breakSeen  <= 1'b0;
    end else begin
      state      <= stateNext;
      frameStart <= startNext;
      frameEnd   <= endNext;
      frameError <= errNext;
      breakSeen  <= brkNext;
    end
  end

  assign inactRun = (state == ST_FRAME);

  assert_err_with_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frameError |-> frameEnd);

  assert_single_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frameStart, frameEnd, breakSeen}));

  assert_armed_before_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frameStart |-> ($past(state) != ST_WAIT_IDLE));

  assert_end_from_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frameEnd |-> ($past(state) == ST_FRAME));

endmodule

// File: rtl/pulse_width_rx.sv
module pulse_width_rx import pwrx_pkg::*; #(
  parameter int CNT_W     = 10,
  parameter int SHORT_MIN = 42,
  parameter int LONG_MIN  = 120,
  parameter int SOF_MIN   = 204,
  parameter int BRK_MIN   = 299,
  parameter int EOF_TICKS = 350,
  parameter int MAX_BYTES = 12,
  parameter int IDX_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tickEn,
  input  logic             busIn,
  output logic [7:0]       byteData,
  output logic             byteValid,
  output logic [IDX_W-1:0] byteIndex,
  output logic             frameStart,
  output logic             frameEnd,
  output logic             frameError,
  output logic             breakSeen
);

  logic     symValid, symLevel, lowIdle;
  symKind_t symKind;
  rxCtrl_t  ctrl;
  logic     inactRun, partialByte, inactDone;

  pwrx_measure #(
    .CNT_W(CNT_W), .SYNC_N(2), .SHORT_MIN(SHORT_MIN), .LONG_MIN(LONG_MIN),
    .SOF_MIN(SOF_MIN), .BRK_MIN(BRK_MIN), .EOF_TICKS(EOF_TICKS)
  ) u_measure (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .busIn(busIn),
    .symValid(symValid), .symKind(symKind), .symLevel(symLevel), .lowIdle(lowIdle)
  );

  pwrx_control u_control (
    .clk(clk), .rst_n(rst_n), .symValid(symValid), .symKind(symKind),
    .symLevel(symLevel), .lowIdle(lowIdle), .inactDone(inactDone),
    .partialByte(partialByte), .ctrl(ctrl), .inactRun(inactRun),
    .frameStart(frameStart), .frameEnd(frameEnd), .frameError(frameError),
    .breakSeen(breakSeen)
  );

  pwrx_datapath #(
    .CNT_W(CNT_W), .EOF_TICKS(EOF_TICKS), .MAX_BYTES(MAX_BYTES), .IDX_W(IDX_W)
  ) u_datapath (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .ctrl(ctrl), .inactRun(inactRun),
    .byteData(byteData), .byteValid(byteValid), .byteIndex(byteIndex),
    .partialByte(partialByte), .inactDone(inactDone)
  );

endmodule

// File: tb/pulse_width_rx_tb.sv
module pulse_width_rx_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tickEn = 1'b1;
  logic       busIn = 1'b0;
  logic [7:0] byteData;
  logic       byteValid;
  logic [3:0] byteIndex;
  logic       frameStart, frameEnd, frameError, breakSeen;

  always #4 clk = ~clk;

  pulse_width_rx u_dut (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .busIn(busIn),
    .byteData(byteData), .byteValid(byteValid), .byteIndex(byteIndex),
    .frameStart(frameStart), .frameEnd(frameEnd), .frameError(frameError),
    .breakSeen(breakSeen)
  );

  int nChecks = 0;
  int nFails = 0;
  int tickDiv = 1;
  int widthMode = 0;   // 0 random, 1 lower bounds, 2 upper bounds
  logic lvlNow = 1'b0;
  logic [7:0] txB [0:15];

  int rxCount, nStart, nEnd, nErr, nBrk;
  logic [7:0] rxData [0:31];
  logic [3:0] rxIdx [0:31];

  always @(negedge clk) begin
    tickEn = (tickDiv == 1) ? 1'b1 : ~tickEn;
    if (rst_n) begin
      if (byteValid && rxCount < 32) begin
        rxData[rxCount] = byteData;
        rxIdx[rxCount]  = byteIndex;
        rxCount++;
      end
      if (frameStart) nStart++;
      if (frameEnd)   nEnd++;
      if (frameError) nErr++;
      if (breakSeen)  nBrk++;
    end
  end

  task automatic check(string req, int actual, int expected);
    nChecks++;
    if (actual != expected) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic clearMon();
    rxCount = 0; nStart = 0; nEnd = 0; nErr = 0; nBrk = 0;
  endtask

  task automatic hold(logic lvl, int ticks);
    busIn = lvl;
    repeat (ticks * tickDiv) @(negedge clk);
  endtask

  // short when the bit equals the level (R1 rule)
  function automatic int pickW(logic lvl, logic b);
    bit isShort = (lvl == b);
    if (widthMode == 1) return isShort ? 42 : 120;
    if (widthMode == 2) return isShort ? 119 : 203;
    return isShort ? 50 + int'($urandom % 60) : 130 + int'($urandom % 65);
  endfunction

  function automatic int pickSof();
    if (widthMode == 1) return 204;
    if (widthMode == 2) return 298;
    return 215 + int'($urandom % 75);
  endfunction

  task automatic sendBits(logic [7:0] val, int nb);
    for (int i = 0; i < nb; i++) begin
      hold(lvlNow, pickW(lvlNow, val[7-i]));
      lvlNow = ~lvlNow;
    end
  endtask

  task automatic sendFrame(int nBytes, int extraBits, logic [7:0] extraVal);
    hold(1'b1, pickSof());
    lvlNow = 1'b0;
    for (int k = 0; k < nBytes; k++) sendBits(txB[k], 8);
    if (extraBits > 0) sendBits(extraVal, extraBits);
  endtask

  task automatic endFrame();
    hold(1'b0, 450);
    repeat (6) @(negedge clk);
  endtask

  task automatic checkFrame(string req, int nBytes);
    int expN = (nBytes > 12) ? 12 : nBytes;
    check({req, " byte count"}, rxCount, expN);
    for (int k = 0; k < expN && k < rxCount; k++) begin
      check({req, " byte value"}, int'(rxData[k]), int'(txB[k]));
      check({req, " byte index"}, int'(rxIdx[k]), k);
    end
    check({req, " frame start"}, nStart, 1);
    check({req, " frame end R6"}, nEnd, 1);
    check({req, " no error R7"}, nErr, 0);
    check({req, " no break R2"}, nBrk, 0);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    clearMon();
    repeat (5) @(negedge clk);
    // R12: outputs during reset
    check("R12 reset byteValid", int'(byteValid), 0);
    check("R12 reset frame events", int'({frameStart, frameEnd, frameError, breakSeen}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 after reset byteData", int'(byteData), 0);
    check("R12 after reset byteIndex", int'(byteIndex), 0);

    // R9: frame before the bus has idled is ignored
    hold(1'b0, 20);
    txB[0] = 8'h55;
    sendFrame(1, 0, 8'h00);
    endFrame();
    check("R9 early start ignored", nStart, 0);
    check("R9 early byte ignored", rxCount, 0);
    check("R9 early no end", nEnd, 0);

    // R1 R3 R4: directed two-byte frame
    clearMon();
    txB[0] = 8'hA5; txB[1] = 8'h3C;
    sendFrame(2, 0, 8'h00);
    endFrame();
    checkFrame("R1 R4 directed", 2);

    // R1 R3: lower class bounds (42, 120, 204)
    clearMon(); widthMode = 1;
    txB[0] = 8'h96; txB[1] = 8'h0F;
    sendFrame(2, 0, 8'h00);
    endFrame();
    checkFrame("R1 R3 lower bounds", 2);

    // R1 R3: upper class bounds (119, 203, 298)
    clearMon(); widthMode = 2;
    txB[0] = 8'h69; txB[1] = 8'hF0;
    sendFrame(2, 0, 8'h00);
    endFrame();
    checkFrame("R1 R3 upper bounds", 2);

    // R6: all-long frame longer than the timeout, no early end
    clearMon();
    for (int k = 0; k < 3; k++) txB[k] = 8'hAA;
    sendFrame(3, 0, 8'h00);
    check("R6 no end during frame", nEnd, 0);
    endFrame();
    checkFrame("R6 long frame", 3);
    widthMode = 0;

    // R2: 41-tick glitch ignored
    clearMon();
    hold(1'b1, 41);
    hold(1'b0, 400);
    check("R2 glitch no start", nStart, 0);
    check("R2 glitch no break", nBrk, 0);
    check("R2 glitch no byte", rxCount, 0);

    // R5: 14 bytes, only 12 delivered
    clearMon();
    for (int k = 0; k < 14; k++) txB[k] = 8'(k * 37 + 5);
    sendFrame(14, 0, 8'h00);
    endFrame();
    checkFrame("R5 byte cap", 14);

    // R7: partial byte flagged
    clearMon();
    txB[0] = 8'hC3;
    sendFrame(1, 4, 8'hB0);
    endFrame();
    check("R7 partial byte count", rxCount, 1);
    check("R7 partial end", nEnd, 1);
    check("R7 partial error", nErr, 1);

    // R8: break at exactly 299 ticks mid-frame
    clearMon();
    txB[0] = 8'h5A;
    sendFrame(1, 3, 8'hE0);
    hold(1'b1, 299);
    endFrame();
    check("R8 break seen", nBrk, 1);
    check("R8 no end after break", nEnd, 0);
    check("R8 byte before break", rxCount, 1);
    clearMon();
    txB[0] = 8'h81;
    sendFrame(1, 0, 8'h00);
    endFrame();
    checkFrame("R8 restart index", 1);

    // R10: stuck high past counter range
    clearMon();
    hold(1'b1, 1124);
    hold(1'b0, 400);
    check("R10 saturated break", nBrk, 1);
    check("R10 no start", nStart, 0);
    check("R10 no byte", rxCount, 0);

    // R11: ticks on every other cycle
    clearMon(); tickDiv = 2;
    for (int k = 0; k < 3; k++) txB[k] = 8'($urandom);
    sendFrame(3, 0, 8'h00);
    endFrame();
    checkFrame("R11 slow ticks", 3);
    tickDiv = 1;
    repeat (4) @(negedge clk);

    // R1 R4 R5: random frames
    for (int f = 0; f < 6; f++) begin
      int n = 1 + int'($urandom % 12);
      clearMon();
      for (int k = 0; k < n; k++) txB[k] = 8'($urandom);
      sendFrame(n, 0, 8'h00);
      endFrame();
      checkFrame("R1 R4 random", n);
    end

    finishRun();
  end

endmodule